// File: doc/BRIEF.md
# Banked System Memory Address Decoder

This block turns a 16-bit CPU address into the chip enables of a small home computer's memory system. The low 16 KiB go to two fixed system ROM devices. The next 8 KiB form a window that two EPROMs share, and a one-bit bank input from the I/O controller chooses which of them answers. A wide expansion area goes to the cartridge slot. In that area ROM fills upward from 6000 and RAM fills downward toward the internal RAM, with an optional separate select for a 2 KiB expansion RAM. The 4 KiB internal RAM sits at E000. The ranges the CPU serves from its own on-chip memory get no external select. Instead a flag is raised so that the board stays off the bus.

The decoder is purely combinational. A new address, strobe or bank value shows up on the enables in the same cycle. The video controller drives the same address bus while it holds the CPU, so its fetches are decoded by the same logic with no extra path. All chip enables are active low. The CPU-ownership flag is active high.

Top module: `memdec_top`

## Requirements
- R1: With the memory strobe active and a read (`rd_i`=1), 0000–1FFF drives `rom0_ce_n` low and 2000–3FFF drives `rom1_ce_n` low.
- R2: With the memory strobe active and a read in 4000–5FFF, `bank_ce_n[0]` goes low when `bank_sel_i`=0 and `bank_ce_n[1]` goes low when `bank_sel_i`=1. Never both.
- R3: 6000–BFFF drives `slot_sel_n` low for reads and writes.
- R4: C000–DFFF (top three address bits 110) drives `xram_ce_n` low and leaves `slot_sel_n` high when `XRAM_EN`=1. When `XRAM_EN`=0 the same range drives `slot_sel_n` low and `xram_ce_n` stays high.
- R5: E000–EFFF drives `ram_ce_n` low for reads and writes.
- R6: F000–F0FB and FFFA–FFFF raise `cpu_own_o` and leave every chip enable high.
- R7: F0FC–FFF9 drives `slot_sel_n` low, so expansion RAM can claim it.
- R8: With `mem_en_i`=0, every chip enable is high and `cpu_own_o` is 0.
- R9: A write (`rd_i`=0) anywhere in 0000–5FFF leaves every chip enable high.
- R10: At most one of the chip enables and `cpu_own_o` is active at any time.
- R11: A change of `bank_sel_i` with the address held moves the banked enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | CPU or video-controller address |
| mem_en_i | input | 1 | Memory access strobe, active high |
| rd_i | input | 1 | 1 = read, 0 = write |
| bank_sel_i | input | 1 | Banked-window EPROM choice from the I/O controller |
| rom0_ce_n | output | 1 | System ROM 0000–1FFF enable |
| rom1_ce_n | output | 1 | System ROM 2000–3FFF enable |
| bank_ce_n | output | 2 | Banked EPROM enables, one per bank |
| slot_sel_n | output | 1 | Expansion slot select |
| xram_ce_n | output | 1 | Optional 2 KiB expansion RAM enable |
| ram_ce_n | output | 1 | Internal 4 KiB RAM enable |
| cpu_own_o | output | 1 | Address served by CPU-internal memory |

## Verification
The bench walks every region edge: 1FFF/2000, 3FFF/4000, 5FFF/6000, BFFF/C000, DFFF/E000, EFFF/F000, F0FB/F0FC and FFF9/FFFA. An off-by-one compare would put the boundary word on the neighbouring device, or on two devices at once. It flips the bank bit while the address is held and checks that the other EPROM answers at once, which catches a swapped or stuck bank input. It issues writes into ROM space, where a decoder that ignores the direction would enable a ROM onto a driven bus. A second instance with the expansion-RAM select disabled confirms that C000–DFFF falls back to the slot, and that nothing is left unselected.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

    typedef enum logic [3:0] {
        RG_NONE   = 4'd0,
        RG_ROM0   = 4'd1,
        RG_ROM1   = 4'd2,
        RG_BANKED = 4'd3,
        RG_SLOT   = 4'd4,
        RG_XRAM   = 4'd5,
        RG_IRAM   = 4'd6,
        RG_CPU    = 4'd7
    } region_e;

    // active-high fixed selects
    typedef struct packed {
        logic rom0;
        logic rom1;
        logic slot;
        logic xram;
        logic iram;
        logic cpu;
    } fixed_sel_t;

endpackage

// File: rtl/memdec_region.sv
module memdec_region
    import memdec_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter bit              XRAM_EN     = 1'b1,
    parameter logic [15:0]     ROM0_END    = 16'h1FFF,
    parameter logic [15:0]     ROM1_END    = 16'h3FFF,
    parameter logic [15:0]     BANK_END    = 16'h5FFF,
    parameter logic [15:0]     XRAM_BASE   = 16'hC000,
    parameter logic [15:0]     IRAM_BASE   = 16'hE000,
    parameter logic [15:0]     IRAM_END    = 16'hEFFF,
    parameter logic [15:0]     CPU_LO_END  = 16'hF0FB,
    parameter logic [15:0]     CPU_HI_BASE = 16'hFFFA
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o
);

    localparam int TAG_W = 3;
    localparam logic [TAG_W-1:0] XRAM_TAG = XRAM_BASE[15 -: TAG_W];

    region_e region_d;
    logic    xram_hit_d;

    always_comb begin
        xram_hit_d = XRAM_EN && (addr_i[ADDR_W-1 -: TAG_W] == XRAM_TAG);
        if (addr_i <= ROM0_END[ADDR_W-1:0]) begin
            region_d = RG_ROM0;
        end else if (addr_i <= ROM1_END[ADDR_W-1:0]) begin
            region_d = RG_ROM1;
        end else if (addr_i <= BANK_END[ADDR_W-1:0]) begin
            region_d = RG_BANKED;
        end else if (addr_i < IRAM_BASE[ADDR_W-1:0]) begin
            region_d = xram_hit_d ? RG_XRAM : RG_SLOT;
        end else if (addr_i <= IRAM_END[ADDR_W-1:0]) begin
            region_d = RG_IRAM;
        end else if (addr_i <= CPU_LO_END[ADDR_W-1:0]) begin
            region_d = RG_CPU;
        end else if (addr_i >= CPU_HI_BASE[ADDR_W-1:0]) begin
            region_d = RG_CPU;
        end else begin
            region_d = RG_SLOT;   // gap open to expansion RAM
        end
    end

    assign region_o = region_d;

    // R4: the expansion RAM region only appears with its tag and the enable set
    always_comb begin
        if (!$isunknown(addr_i)) begin
            p_xram_tag_r4: assert ((region_o != RG_XRAM) ||
                                   (XRAM_EN && addr_i[ADDR_W-1 -: TAG_W] == 3'b110))
                else $error("p_xram_tag_r4 failed");
        end
    end

endmodule

// File: rtl/memdec_bank.sv
module memdec_bank
    import memdec_pkg::*;
#(
    parameter int BANK_W = 1,
    localparam int BANKS = 1 << BANK_W
) (
    input  region_e           region_i,
    input  logic              rd_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    output logic [BANKS-1:0]  bank_hot_o
);

    logic window_d;
    logic [BANKS-1:0] hot_d;

    always_comb window_d = (region_i == RG_BANKED) && rd_i;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        always_comb hot_d[g] = window_d && (bank_sel_i == BANK_W'(g));
    end

    assign bank_hot_o = hot_d;

    // R2: one bank at most, exactly one on a banked read
    always_comb begin
        if (!$isunknown({region_i, rd_i, bank_sel_i})) begin
            p_bank_single_r2: assert ($onehot0(bank_hot_o))
                else $error("p_bank_single_r2 failed");
            p_bank_read_r2: assert (!(region_i == RG_BANKED && rd_i) ||
                                    ($countones(bank_hot_o) == 1))
                else $error("p_bank_read_r2 failed");
        end
    end

endmodule

// File: rtl/memdec_drive.sv
module memdec_drive
    import memdec_pkg::*;
(
    input  region_e    region_i,
    input  logic       mem_en_i,
    input  logic       rd_i,
    output fixed_sel_t sel_o
);

    fixed_sel_t sel_d;

    always_comb begin
        sel_d = '0;
        if (mem_en_i) begin
            unique case (region_i)
                RG_ROM0:   sel_d.rom0 = rd_i;
                RG_ROM1:   sel_d.rom1 = rd_i;
                RG_SLOT:   sel_d.slot = 1'b1;
                RG_XRAM:   sel_d.xram = 1'b1;
                RG_IRAM:   sel_d.iram = 1'b1;
                RG_CPU:    sel_d.cpu  = 1'b1;
                default:   sel_d = '0;
            endcase
        end
    end

    assign sel_o = sel_d;

    // R9: a write never enables ROM
    always_comb begin
        if (!$isunknown({mem_en_i, rd_i})) begin
            p_rom_write_r9: assert (rd_i || !(sel_o.rom0 || sel_o.rom1))
                else $error("p_rom_write_r9 failed");
            p_idle_r8: assert (mem_en_i || (sel_o == '0))
                else $error("p_idle_r8 failed");
        end
    end

endmodule

// File: rtl/memdec_top.sv
module memdec_top
    import memdec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 1,
    parameter bit XRAM_EN = 1'b1,
    localparam int BANKS  = 1 << BANK_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mem_en_i,
    input  logic              rd_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    output logic              rom0_ce_n,
    output logic              rom1_ce_n,
    output logic [BANKS-1:0]  bank_ce_n,
    output logic              slot_sel_n,
    output logic              xram_ce_n,
    output logic              ram_ce_n,
    output logic              cpu_own_o
);

    region_e          region_w;
    fixed_sel_t       fixed_w;
    logic [BANKS-1:0] bank_hot_w;
    logic [BANKS-1:0] bank_gated_d;

    memdec_region #(
        .ADDR_W  (ADDR_W),
        .XRAM_EN (XRAM_EN)
    ) u_region (
        .addr_i   (addr_i),
        .region_o (region_w)
    );

    memdec_bank #(
        .BANK_W (BANK_W)
    ) u_bank (
        .region_i   (region_w),
        .rd_i       (rd_i),
        .bank_sel_i (bank_sel_i),
        .bank_hot_o (bank_hot_w)
    );

    memdec_drive u_drive (
        .region_i (region_w),
        .mem_en_i (mem_en_i),
        .rd_i     (rd_i),
        .sel_o    (fixed_w)
    );

    always_comb begin
        bank_gated_d = mem_en_i ? bank_hot_w : '0;
        rom0_ce_n    = ~fixed_w.rom0;
        rom1_ce_n    = ~fixed_w.rom1;
        bank_ce_n    = ~bank_gated_d;
        slot_sel_n   = ~fixed_w.slot;
        xram_ce_n    = ~fixed_w.xram;
        ram_ce_n     = ~fixed_w.iram;
        cpu_own_o    = fixed_w.cpu;
    end

    // R10 / R6 / R8 at the pins
    always_comb begin
        if (!$isunknown({addr_i, mem_en_i, rd_i, bank_sel_i})) begin
            p_one_target_r10: assert ($onehot0({~rom0_ce_n, ~rom1_ce_n, ~bank_ce_n,
                                                ~slot_sel_n, ~xram_ce_n, ~ram_ce_n,
                                                cpu_own_o}))
                else $error("p_one_target_r10 failed");
            p_cpu_quiet_r6: assert (!cpu_own_o ||
                                    (&{rom0_ce_n, rom1_ce_n, bank_ce_n,
                                       slot_sel_n, xram_ce_n, ram_ce_n}))
                else $error("p_cpu_quiet_r6 failed");
            p_strobe_gate_r8: assert (mem_en_i || (!cpu_own_o &&
                                    (&{rom0_ce_n, rom1_ce_n, bank_ce_n,
                                       slot_sel_n, xram_ce_n, ram_ce_n})))
                else $error("p_strobe_gate_r8 failed");
        end
    end

endmodule

// File: tb/memdec_top_tb.sv
module memdec_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        mem_en = 1'b0;
    logic        rd = 1'b1;
    logic        bank = 1'b0;

    logic        a_rom0, a_rom1, a_slot, a_xram, a_ram, a_cpu;
    logic [1:0]  a_bank;
    logic        b_rom0, b_rom1, b_slot, b_xram, b_ram, b_cpu;
    logic [1:0]  b_bank;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    memdec_top #(.XRAM_EN(1'b1)) u_dut (
        .addr_i(addr), .mem_en_i(mem_en), .rd_i(rd), .bank_sel_i(bank),
        .rom0_ce_n(a_rom0), .rom1_ce_n(a_rom1), .bank_ce_n(a_bank),
        .slot_sel_n(a_slot), .xram_ce_n(a_xram), .ram_ce_n(a_ram),
        .cpu_own_o(a_cpu)
    );

    memdec_top #(.XRAM_EN(1'b0)) u_dut_plain (
        .addr_i(addr), .mem_en_i(mem_en), .rd_i(rd), .bank_sel_i(bank),
        .rom0_ce_n(b_rom0), .rom1_ce_n(b_rom1), .bank_ce_n(b_bank),
        .slot_sel_n(b_slot), .xram_ce_n(b_xram), .ram_ce_n(b_ram),
        .cpu_own_o(b_cpu)
    );

    // expected vector {rom0_n, rom1_n, bank_n[1], bank_n[0], slot_n, xram_n, ram_n, cpu}
    function automatic logic [7:0] model(int a, bit en, bit r, bit b, bit xe);
        logic [7:0] act = '0;   // active-high view
        if (en) begin
            if (a <= 'h1FFF)       act[7] = r;
            else if (a <= 'h3FFF)  act[6] = r;
            else if (a <= 'h5FFF) begin
                if (r) begin
                    if (b) act[5] = 1'b1; else act[4] = 1'b1;
                end
            end
            else if (a <= 'hBFFF)  act[3] = 1'b1;
            else if (a <= 'hDFFF) begin
                if (xe) act[2] = 1'b1; else act[3] = 1'b1;
            end
            else if (a <= 'hEFFF)  act[1] = 1'b1;
            else if (a <= 'hF0FB)  act[0] = 1'b1;
            else if (a >= 'hFFFA)  act[0] = 1'b1;
            else                   act[3] = 1'b1;
        end
        return {~act[7:1], act[0]};
    endfunction

    function automatic string tag(int a, bit en, bit r, bit xe);
        if (!en) return "R8";
        if (!r && a <= 'h5FFF) return "R9";
        if (a <= 'h3FFF) return "R1";
        if (a <= 'h5FFF) return "R2";
        if (a <= 'hBFFF) return "R3";
        if (a <= 'hDFFF) return xe ? "R4" : "R4(plain)";
        if (a <= 'hEFFF) return "R5";
        if (a <= 'hF0FB || a >= 'hFFFA) return "R6";
        return "R7";
    endfunction

    task automatic check_now(string req_override);
        logic [7:0] got_a, got_b, exp_a, exp_b;
        string ta, tb_s;
        got_a = {a_rom0, a_rom1, a_bank[1], a_bank[0], a_slot, a_xram, a_ram, a_cpu};
        got_b = {b_rom0, b_rom1, b_bank[1], b_bank[0], b_slot, b_xram, b_ram, b_cpu};
        exp_a = model(int'(addr), mem_en, rd, bank, 1'b1);
        exp_b = model(int'(addr), mem_en, rd, bank, 1'b0);
        ta   = (req_override != "") ? req_override : tag(int'(addr), mem_en, rd, 1'b1);
        tb_s = (req_override != "") ? req_override : tag(int'(addr), mem_en, rd, 1'b0);
        checks++;
        if (got_a !== exp_a) begin
            failures++;
            $display("FAIL %s addr=%h en=%0b rd=%0b bank=%0b actual=%b expected=%b",
                     ta, addr, mem_en, rd, bank, got_a, exp_a);
        end
        checks++;
        if (got_b !== exp_b) begin
            failures++;
            $display("FAIL %s plain addr=%h en=%0b rd=%0b bank=%0b actual=%b expected=%b",
                     tb_s, addr, mem_en, rd, bank, got_b, exp_b);
        end
        // R10: never more than one target active
        checks++;
        if ($countones({~got_a[7:1], got_a[0]}) > 1) begin
            failures++;
            $display("FAIL R10 addr=%h actual=%b expected=at most one active", addr, got_a);
        end
    endtask

    task automatic apply(logic [15:0] a, bit en, bit r, bit b, string req);
        @(posedge clk);
        #1;
        addr = a; mem_en = en; rd = r; bank = b;
        @(negedge clk);
        check_now(req);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] edges [17] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000,
                                    16'h5FFF, 16'h6000, 16'hBFFF, 16'hC000, 16'hDFFF,
                                    16'hE000, 16'hEFFF, 16'hF000, 16'hF0FB, 16'hF0FC,
                                    16'hFFF9, 16'hFFFA};
        // reset state: strobe idle, nothing selected (R8)
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R8");

        // boundary words, all bank and direction combinations
        foreach (edges[i]) begin
            for (int r = 0; r < 2; r++) begin
                for (int b = 0; b < 2; b++) begin
                    apply(edges[i], 1'b1, r[0], b[0], "");
                end
            end
            apply(edges[i], 1'b0, 1'b1, 1'b0, "R8");
            apply(edges[i], 1'b0, 1'b0, 1'b1, "R8");
        end
        apply(16'hFFFF, 1'b1, 1'b1, 1'b0, "R6");

        // coarse sweep of the whole space
        for (int a = 0; a < 65536; a += 48) begin
            for (int r = 0; r < 2; r++) begin
                apply(16'(a), 1'b1, r[0], a[4], "");
            end
        end

        // R11: bank flips with address held, enable follows at once
        for (int k = 0; k < 8; k++) begin
            apply(16'h4000 + 16'(k * 16'h0400), 1'b1, 1'b1, k[0], "R11");
            apply(16'h4000 + 16'(k * 16'h0400), 1'b1, 1'b1, ~k[0], "R11");
        end

        // strobe toggling inside internal RAM (R5, R8)
        for (int k = 0; k < 4; k++) begin
            apply(16'hE800, k[0], k[1], 1'b0, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule